// File: doc/BRIEF.md
# Write-Through Data Cache with Lockable Lines

A two-way set-associative, physically addressed data cache that sits between a CPU load/store port and an external memory port. Cacheable loads that hit return data in the same cycle with no memory transaction. A load miss refills either one word or a whole line, as selected by a burst enable. Before the refill starts, all queued stores must reach memory, so the refill never reads a stale location. Stores never allocate. A store to an unlocked resident line updates the cache and is also queued in a small write buffer. The CPU only waits on a store when that buffer is full.

Lines can be pinned in three ways. A per-access lock flag locks the line an access touches. A sticky auto-lock input does the same for every cacheable access made while it is high. A global lock input stops any valid line from being replaced but still lets invalid ways be filled. Stores to a locked line stay in the cache and are never sent to memory, so locked lines act as on-chip scratch RAM. A single pulse releases every lock. Each access carries a cacheable flag, and non-cacheable accesses go straight to memory.

Top module: `dcache_wt`

## Requirements
- R1: After reset, all lines are invalid and unlocked, and the write buffer is empty. With no CPU request, `cpu_ready_o` and `mem_req_o` are low.
- R2: A cacheable load to a valid word of a resident line sets `cpu_ready_o` in the cycle it is presented, returns the cached word and causes no memory transaction.
- R3: A cacheable load miss on a line that is not resident allocates a way. With `burst_en_i` high it reads all words of the line in ascending order from word 0. Otherwise it reads only the requested word. If the tag is resident but the word is invalid, only that word is read into the existing line. With an empty buffer, `cpu_ready_o` rises three cycles after the request for a single read and six cycles after it for a four-word burst.
- R4: A cacheable store that hits an unlocked line writes the cached word and also writes the same address and data to memory.
- R5: A store miss writes memory only. A later load of that address misses and returns the stored value.
- R6: A non-cacheable load reads one word from memory every time, whatever the burst setting, and never allocates. A non-cacheable store goes to memory and leaves the cache unchanged.
- R7: A cacheable store whose line was already locked before the access updates the cache and produces no memory write.
- R8: A cacheable access made with `cpu_lock_i` high, or while `auto_lock_i` is high, locks the line it hits or allocates.
- R9: While `global_lock_i` is high, a load miss may fill an invalid way but never replaces a valid line. If neither way is free, the word is read from memory without allocation. When global lock is low, a locked line is never chosen as the victim.
- R10: A one-cycle pulse on `unlock_all_i` clears every lock bit. Later stores to such lines write through again.
- R11: The write buffer holds 4 entries. A store that needs it is accepted in the cycle it is presented unless the buffer is full, and stalls while it stays full.
- R12: A load that must read memory issues no read until every buffered write has completed.
- R13: On allocation the lowest invalid way is chosen. If both ways are valid and unlocked, the victim alternates per set, starting with way 1 after way 0 was filled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cpu_req_i | input | 1 | CPU access request, held until ready |
| cpu_we_i | input | 1 | 1 = store, 0 = load |
| cpu_addr_i | input | ADDR_W | Byte address (word aligned) |
| cpu_wdata_i | input | DATA_W | Store data |
| cpu_cacheable_i | input | 1 | Access may use the cache |
| cpu_lock_i | input | 1 | Lock the line this access touches |
| cpu_ready_o | output | 1 | Access completes this cycle |
| cpu_rdata_o | output | DATA_W | Load data, valid with ready |
| global_lock_i | input | 1 | Forbid replacement of valid lines |
| auto_lock_i | input | 1 | Lock every line accessed while high |
| unlock_all_i | input | 1 | Pulse: clear all lock bits |
| burst_en_i | input | 1 | Refill a whole line on allocation |
| mem_req_o | output | 1 | Memory transaction request |
| mem_we_o | output | 1 | 1 = write, 0 = read |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_wdata_o | output | DATA_W | Memory write data |
| mem_ack_i | input | 1 | Transaction completes this cycle |
| mem_rdata_i | input | DATA_W | Read data, valid with ack |

## Verification
The hardest situation to reach is the ordering between a full or busy write buffer and a following load miss. Stores are accepted at once, so the buffer drains before anything can be observed unless memory is slowed down. The bench therefore models memory with a hold switch that withholds acknowledges. It queues four stores and checks that a fifth one stalls. It then queues stores and launches a load miss in parallel, and records how many writes had completed when the first read appeared. Replacement order and lock protection are reached by sweeping every set through a fixed sequence of three tags, where the expected read count of each access follows from the alternation rule.

// File: rtl/dc_pkg.sv
package dc_pkg;
  localparam int WAYS = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_DRAIN,
    ST_FILL,
    ST_RESP
  } dc_state_e;
endpackage

// File: rtl/dc_wbuf.sv
module dc_wbuf #(
  parameter int DEPTH = 4,
  parameter int W     = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  input  logic         pop_i,
  output logic [W-1:0] data_o,
  output logic         full_o,
  output logic         empty_o
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic [W-1:0]     ent_q [DEPTH];
  logic [PTR_W-1:0] wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0] cnt_q;

  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign empty_o = (cnt_q == '0);
  assign data_o  = ent_q[rd_ptr_q];

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_i) wr_ptr_q <= nxt(wr_ptr_q);
      if (pop_i)  rd_ptr_q <= nxt(rd_ptr_q);
      if (push_i && !pop_i)      cnt_q <= cnt_q + 1'b1;
      else if (pop_i && !push_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_i) ent_q[wr_ptr_q] <= data_i;
  end

  p_no_overflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (push_i && !pop_i) |-> (cnt_q < CNT_W'(DEPTH)));
  p_no_underflow_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q != '0));
endmodule

// File: rtl/dc_ways.sv
module dc_ways #(
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4,
  parameter int TAG_W      = 21,
  parameter int DATA_W     = 32
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic [$clog2(SETS)-1:0]              rd_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0]        rd_word_i,
  input  logic [TAG_W-1:0]                     tag_i,
  output logic [dc_pkg::WAYS-1:0]              hit_o,
  output logic [dc_pkg::WAYS-1:0]              wvld_o,
  output logic [dc_pkg::WAYS-1:0]              vld_o,
  output logic [dc_pkg::WAYS-1:0]              lck_o,
  output logic [dc_pkg::WAYS-1:0][DATA_W-1:0]  rdata_o,
  output logic                                 rr_o,
  input  logic                                 wr_en_i,
  input  logic                                 wr_way_i,
  input  logic [$clog2(SETS)-1:0]              wr_idx_i,
  input  logic [$clog2(LINE_WORDS)-1:0]        wr_word_i,
  input  logic [DATA_W-1:0]                    wr_data_i,
  input  logic                                 alloc_en_i,
  input  logic                                 alloc_way_i,
  input  logic [TAG_W-1:0]                     alloc_tag_i,
  input  logic                                 lock_en_i,
  input  logic                                 lock_way_i,
  input  logic                                 unlock_all_i
);
  import dc_pkg::*;

  logic [SETS-1:0] rr_q;
  assign rr_o = rr_q[rd_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rr_q <= '0;
    else if (alloc_en_i) rr_q[rd_idx_i] <= ~alloc_way_i;
  end

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    logic [TAG_W-1:0]      tag_q [SETS];
    logic [LINE_WORDS-1:0] wv_q  [SETS];
    logic [DATA_W-1:0]     dat_q [SETS][LINE_WORDS];
    logic [SETS-1:0]       vld_q, lck_q;
    logic                  sel_alloc, sel_wr, sel_lock;

    assign sel_alloc = alloc_en_i && (alloc_way_i == 1'(g));
    assign sel_wr    = wr_en_i    && (wr_way_i    == 1'(g));
    assign sel_lock  = lock_en_i  && (lock_way_i  == 1'(g));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        vld_q <= '0;
        lck_q <= '0;
        for (int s = 0; s < SETS; s++) wv_q[s] <= '0;
      end else begin
        if (sel_alloc) begin
          vld_q[rd_idx_i] <= 1'b1;
          wv_q[rd_idx_i]  <= '0;
        end
        if (sel_wr) wv_q[wr_idx_i][wr_word_i] <= 1'b1;
        if (unlock_all_i) lck_q <= '0;
        if (sel_lock) lck_q[rd_idx_i] <= 1'b1;
      end
    end

    always_ff @(posedge clk_i) begin
      if (sel_alloc) tag_q[rd_idx_i] <= alloc_tag_i;
      if (sel_wr)    dat_q[wr_idx_i][wr_word_i] <= wr_data_i;
    end

    assign vld_o[g]   = vld_q[rd_idx_i];
    assign lck_o[g]   = lck_q[rd_idx_i];
    assign hit_o[g]   = vld_q[rd_idx_i] && (tag_q[rd_idx_i] == tag_i);
    assign wvld_o[g]  = wv_q[rd_idx_i][rd_word_i];
    assign rdata_o[g] = dat_q[rd_idx_i][rd_word_i];
  end

  p_single_hit_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit_o) <= 1);
  p_alloc_not_hit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en_i |-> (hit_o == '0));
endmodule

// File: rtl/dcache_wt.sv
module dcache_wt #(
  parameter int ADDR_W     = 32,
  parameter int DATA_W     = 32,
  parameter int SETS       = 128,
  parameter int LINE_WORDS = 4,
  parameter int WB_DEPTH   = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cpu_req_i,
  input  logic              cpu_we_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_wdata_i,
  input  logic              cpu_cacheable_i,
  input  logic              cpu_lock_i,
  output logic              cpu_ready_o,
  output logic [DATA_W-1:0] cpu_rdata_o,
  input  logic              global_lock_i,
  input  logic              auto_lock_i,
  input  logic              unlock_all_i,
  input  logic              burst_en_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o,
  input  logic              mem_ack_i,
  input  logic [DATA_W-1:0] mem_rdata_i
);
  import dc_pkg::*;

  localparam int WORD_W = $clog2(LINE_WORDS);
  localparam int IDX_W  = $clog2(SETS);
  localparam int LINE_W = ADDR_W - WORD_W - 2;
  localparam int TAG_W  = LINE_W - IDX_W;
  localparam int ENT_W  = ADDR_W + DATA_W;
  localparam logic [WORD_W-1:0] LAST_WORD = WORD_W'(LINE_WORDS - 1);

  logic [IDX_W-1:0]  a_idx;
  logic [WORD_W-1:0] a_word;
  logic [TAG_W-1:0]  a_tag;
  logic [LINE_W-1:0] a_line;
  logic              unused_addr;

  assign a_line      = cpu_addr_i[ADDR_W-1:WORD_W+2];
  assign a_idx       = a_line[IDX_W-1:0];
  assign a_tag       = a_line[LINE_W-1:IDX_W];
  assign a_word      = cpu_addr_i[WORD_W+1:2];
  assign unused_addr = ^cpu_addr_i[1:0];

  dc_state_e state_q;
  logic [LINE_W-1:0] f_line_q;
  logic [WORD_W-1:0] f_rword_q, cnt_q;
  logic              f_way_q, f_alloc_q, f_burst_q;
  logic [DATA_W-1:0] cap_q;

  // way array
  logic [WAYS-1:0]             hit, wvld, vld, lck;
  logic [WAYS-1:0][DATA_W-1:0] rdata_w;
  logic                        rr;
  logic                        arr_wr_en, arr_wr_way;
  logic [IDX_W-1:0]            arr_wr_idx;
  logic [WORD_W-1:0]           arr_wr_word;
  logic [DATA_W-1:0]           arr_wr_data;
  logic                        alloc_en, lock_en, lock_way;

  dc_ways #(
    .SETS(SETS), .LINE_WORDS(LINE_WORDS), .TAG_W(TAG_W), .DATA_W(DATA_W)
  ) i_ways (
    .clk_i, .rst_ni,
    .rd_idx_i(a_idx), .rd_word_i(a_word), .tag_i(a_tag),
    .hit_o(hit), .wvld_o(wvld), .vld_o(vld), .lck_o(lck), .rdata_o(rdata_w), .rr_o(rr),
    .wr_en_i(arr_wr_en), .wr_way_i(arr_wr_way), .wr_idx_i(arr_wr_idx),
    .wr_word_i(arr_wr_word), .wr_data_i(arr_wr_data),
    .alloc_en_i(alloc_en), .alloc_way_i(vict), .alloc_tag_i(a_tag),
    .lock_en_i(lock_en), .lock_way_i(lock_way), .unlock_all_i
  );

  // write buffer
  logic             wb_push, wb_pop, wb_full, wb_empty;
  logic [ENT_W-1:0] wb_head;

  dc_wbuf #(.DEPTH(WB_DEPTH), .W(ENT_W)) i_wbuf (
    .clk_i, .rst_ni,
    .push_i(wb_push), .data_i({cpu_addr_i, cpu_wdata_i}),
    .pop_i(wb_pop), .data_o(wb_head), .full_o(wb_full), .empty_o(wb_empty)
  );

  // lookup classification
  logic idle, fill, hw, tag_hit, hit_lck, ld_hit, ld_miss, st_local, st_push;
  logic can_alloc, vict;

  assign idle     = (state_q == ST_IDLE);
  assign fill     = (state_q == ST_FILL);
  assign hw       = hit[1];
  assign tag_hit  = cpu_cacheable_i && (|hit);
  assign hit_lck  = |(hit & lck);
  assign ld_hit   = idle && cpu_req_i && !cpu_we_i && tag_hit && (|(hit & wvld));
  assign ld_miss  = idle && cpu_req_i && !cpu_we_i && !ld_hit;
  assign st_local = idle && cpu_req_i && cpu_we_i && tag_hit && hit_lck;
  assign st_push  = idle && cpu_req_i && cpu_we_i && !st_local && !wb_full;
  assign wb_push  = st_push;
  assign wb_pop   = !fill && !wb_empty && mem_ack_i;

  // victim choice: invalid first, then unlocked, alternate when both free
  always_comb begin
    can_alloc = 1'b0;
    vict      = 1'b0;
    if (!vld[0]) begin
      can_alloc = 1'b1;
    end else if (!vld[1]) begin
      can_alloc = 1'b1;
      vict      = 1'b1;
    end else if (!global_lock_i) begin
      if (!lck[0] && !lck[1]) begin
        can_alloc = 1'b1;
        vict      = rr;
      end else if (!lck[0]) begin
        can_alloc = 1'b1;
      end else if (!lck[1]) begin
        can_alloc = 1'b1;
        vict      = 1'b1;
      end
    end
  end

  assign alloc_en = ld_miss && cpu_cacheable_i && !tag_hit && can_alloc;
  assign lock_en  = (cpu_lock_i || auto_lock_i) &&
                    ((tag_hit && (ld_hit || st_local || st_push)) || alloc_en);
  assign lock_way = tag_hit ? hw : vict;

  always_comb begin
    arr_wr_en   = 1'b0;
    arr_wr_way  = hw;
    arr_wr_idx  = a_idx;
    arr_wr_word = a_word;
    arr_wr_data = cpu_wdata_i;
    if (fill) begin
      arr_wr_en   = mem_ack_i && f_alloc_q;
      arr_wr_way  = f_way_q;
      arr_wr_idx  = f_line_q[IDX_W-1:0];
      arr_wr_word = cnt_q;
      arr_wr_data = mem_rdata_i;
    end else if (idle) begin
      arr_wr_en = st_local || (st_push && tag_hit);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      f_line_q  <= '0;
      f_rword_q <= '0;
      f_way_q   <= 1'b0;
      f_alloc_q <= 1'b0;
      f_burst_q <= 1'b0;
      cnt_q     <= '0;
      cap_q     <= '0;
    end else begin
      unique case (state_q)
        ST_IDLE: if (ld_miss) begin
          state_q   <= ST_DRAIN;
          f_line_q  <= a_line;
          f_rword_q <= a_word;
          f_way_q   <= tag_hit ? hw : vict;
          f_alloc_q <= tag_hit || alloc_en;
          f_burst_q <= alloc_en && burst_en_i;
          cnt_q     <= (alloc_en && burst_en_i) ? '0 : a_word;
        end
        ST_DRAIN: if (wb_empty) state_q <= ST_FILL;
        ST_FILL: if (mem_ack_i) begin
          if (cnt_q == f_rword_q) cap_q <= mem_rdata_i;
          if (!f_burst_q || cnt_q == LAST_WORD) state_q <= ST_RESP;
          else cnt_q <= cnt_q + 1'b1;
        end
        ST_RESP: state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cpu_ready_o = (state_q == ST_RESP) || ld_hit || st_local || st_push;
  assign cpu_rdata_o = (state_q == ST_RESP) ? cap_q : rdata_w[hw];

  assign mem_req_o   = fill || !wb_empty;
  assign mem_we_o    = !fill;
  assign mem_addr_o  = fill ? {f_line_q, cnt_q, 2'b00} : wb_head[ENT_W-1:DATA_W];
  assign mem_wdata_o = wb_head[DATA_W-1:0];

  p_read_after_drain_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o) |-> wb_empty);
  p_locked_stays_local_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && cpu_req_i && cpu_we_i && cpu_cacheable_i && hit_lck) |-> !wb_push);
  p_keep_valid_glock_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_en && global_lock_i) |-> !vld[vict]);
  p_no_locked_victim_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    alloc_en |-> !(vld[vict] && lck[vict]));
  p_resp_one_cycle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RESP) |=> (state_q == ST_IDLE));
  p_idle_quiet_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle && !cpu_req_i) |-> !cpu_ready_o);
endmodule

// File: tb/test_dcache_wt.sv
module test_dcache_wt;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        cpu_req_i = 1'b0, cpu_we_i = 1'b0, cpu_cacheable_i = 1'b1, cpu_lock_i = 1'b0;
  logic [31:0] cpu_addr_i = '0, cpu_wdata_i = '0;
  logic        cpu_ready_o;
  logic [31:0] cpu_rdata_o;
  logic        global_lock_i = 1'b0, auto_lock_i = 1'b0, unlock_all_i = 1'b0, burst_en_i = 1'b0;
  logic        mem_req_o, mem_we_o, mem_ack_i = 1'b0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i = '0;

  always #5 clk_i = ~clk_i;

  dcache_wt #(.SETS(4), .LINE_WORDS(4), .WB_DEPTH(4)) i_dcache_wt (.*);

  int n_tests = 0, n_fail = 0;
  int n_rd = 0, n_wr = 0, last_rd_wr = 0;
  bit hold = 1'b0;
  logic [31:0] mem_m [int unsigned];
  logic [31:0] res;
  int acc_cyc;
  bit acc_done;

  function automatic logic [31:0] base(input logic [31:0] a);
    return {a[15:0] ^ 16'h5a5a, a[15:0]};
  endfunction
  function automatic logic [31:0] mval(input logic [31:0] a);
    return mem_m.exists(a) ? mem_m[a] : base(a);
  endfunction
  function automatic logic [31:0] adr(input int t, input int s, input int w);
    return 32'((t << 6) | (s << 4) | (w << 2));
  endfunction

  // memory model: decide handshake at negedge, outputs are stable until the edge
  always @(negedge clk_i) begin
    if (mem_req_o && !hold) begin
      mem_ack_i = 1'b1;
      if (mem_we_o) begin
        mem_m[mem_addr_o] = mem_wdata_o;
        n_wr++;
      end else begin
        mem_rdata_i = mval(mem_addr_o);
        n_rd++;
        last_rd_wr = n_wr;
      end
    end else begin
      mem_ack_i = 1'b0;
    end
  end

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic acc(input logic we, input logic [31:0] a, input logic [31:0] d,
                     input logic nc, input logic lk);
    int cyc = 0;
    acc_done = 1'b0;
    @(negedge clk_i);
    cpu_req_i = 1'b1; cpu_we_i = we; cpu_addr_i = a; cpu_wdata_i = d;
    cpu_cacheable_i = !nc; cpu_lock_i = lk;
    #1;
    while (!cpu_ready_o) begin
      @(negedge clk_i); #1; cyc++;
    end
    res = cpu_rdata_o;
    acc_cyc = cyc;
    @(posedge clk_i); #1;
    cpu_req_i = 1'b0; cpu_lock_i = 1'b0;
    acc_done = 1'b1;
  endtask

  task automatic ld(input logic [31:0] a, input logic nc = 1'b0, input logic lk = 1'b0);
    acc(1'b0, a, '0, nc, lk);
  endtask
  task automatic st(input logic [31:0] a, input logic [31:0] d,
                    input logic nc = 1'b0, input logic lk = 1'b0);
    acc(1'b1, a, d, nc, lk);
  endtask

  task automatic do_reset();
    rst_ni = 1'b0; hold = 1'b0; cpu_req_i = 1'b0;
    global_lock_i = 1'b0; auto_lock_i = 1'b0; unlock_all_i = 1'b0;
    mem_m.delete();
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk_i);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk_i);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=0", 1);
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin : main
    int r0, w0;
    do_reset();
    // R1 reset state
    chk("R1 ready idle", {31'b0, cpu_ready_o}, 32'd0);
    chk("R1 mem_req idle", {31'b0, mem_req_o}, 32'd0);
    r0 = n_rd;
    ld(adr(9, 1, 1));
    chk("R1 all invalid: first load misses", n_rd - r0, 1);

    // Sweep, single-word refill: R3 single, R2 hit
    do_reset();
    burst_en_i = 1'b0;
    for (int s = 0; s < 4; s++) begin
      for (int w = 0; w < 4; w++) begin
        r0 = n_rd;
        ld(adr(1, s, w));
        chk("R3 single refill reads", n_rd - r0, 1);
        chk("R3 single refill data", res, base(adr(1, s, w)));
        if (w == 0) chk("R3 single refill latency", acc_cyc, 3);
        r0 = n_rd;
        ld(adr(1, s, w));
        chk("R2 hit no bus cycle", n_rd - r0, 0);
        chk("R2 hit same cycle", acc_cyc, 0);
        chk("R2 hit data", res, base(adr(1, s, w)));
      end
    end

    // Burst refill and replacement order: R3, R13
    burst_en_i = 1'b1;
    for (int s = 0; s < 4; s++) begin
      r0 = n_rd;
      ld(adr(2, s, 0));
      chk("R3 burst reads", n_rd - r0, 4);
      chk("R3 burst latency", acc_cyc, 6);
      r0 = n_rd;
      for (int w = 1; w < 4; w++) begin
        ld(adr(2, s, w));
        chk("R3 burst words present", res, base(adr(2, s, w)));
      end
      ld(adr(1, s, 3));
      chk("R13 invalid way taken, old line kept", n_rd - r0, 0);
      r0 = n_rd;
      ld(adr(3, s, 2));
      chk("R13 third tag burst", n_rd - r0, 4);
      r0 = n_rd;
      ld(adr(2, s, 3));
      chk("R13 way1 survives", n_rd - r0, 0);
      ld(adr(1, s, 1));
      chk("R13 way0 evicted", n_rd - r0, 4);
      r0 = n_rd;
      ld(adr(3, s, 0));
      chk("R13 alternation keeps tag3", n_rd - r0, 0);
      ld(adr(2, s, 0));
      chk("R13 alternation evicted tag2", n_rd - r0, 4);
    end

    // Stores: R4, R5, R6
    do_reset();
    burst_en_i = 1'b1;
    r0 = n_rd; w0 = n_wr;
    st(adr(4, 0, 1), 32'hCAFE_0001);
    chk("R11 store accepted same cycle", acc_cyc, 0);
    settle();
    chk("R5 store miss writes memory", n_wr - w0, 1);
    chk("R5 memory value", mval(adr(4, 0, 1)), 32'hCAFE_0001);
    chk("R5 no allocation on store", n_rd - r0, 0);
    ld(adr(4, 0, 1));
    chk("R5 later load misses", n_rd - r0, 4);
    chk("R5 later load data", res, 32'hCAFE_0001);
    w0 = n_wr; r0 = n_rd;
    st(adr(4, 0, 2), 32'hCAFE_0002);
    settle();
    chk("R4 hit writes through", n_wr - w0, 1);
    chk("R4 memory value", mval(adr(4, 0, 2)), 32'hCAFE_0002);
    ld(adr(4, 0, 2));
    chk("R4 cache updated", res, 32'hCAFE_0002);
    chk("R4 load after store hits", n_rd - r0, 0);
    r0 = n_rd;
    ld(adr(5, 1, 0), 1'b1);
    chk("R6 nc load single word", n_rd - r0, 1);
    chk("R6 nc load data", res, base(adr(5, 1, 0)));
    ld(adr(5, 1, 0), 1'b1);
    chk("R6 nc load no allocate", n_rd - r0, 2);
    st(adr(4, 0, 3), 32'hBEEF_0003, 1'b1);
    settle();
    chk("R6 nc store to memory", mval(adr(4, 0, 3)), 32'hBEEF_0003);
    r0 = n_rd;
    ld(adr(4, 0, 3));
    chk("R6 nc store leaves cache", res, base(adr(4, 0, 3)));
    chk("R6 cached copy still hits", n_rd - r0, 0);

    // Locks: R7, R8, R9, R10
    do_reset();
    burst_en_i = 1'b1;
    ld(adr(6, 2, 0), 1'b0, 1'b1);
    w0 = n_wr; r0 = n_rd;
    st(adr(6, 2, 1), 32'h1111_2222);
    settle();
    chk("R7 locked store no memory write", n_wr - w0, 0);
    chk("R7 memory unchanged", mval(adr(6, 2, 1)), base(adr(6, 2, 1)));
    ld(adr(6, 2, 1));
    chk("R7 locked store in cache", res, 32'h1111_2222);
    chk("R7 locked load hits", n_rd - r0, 0);
    auto_lock_i = 1'b1;
    ld(adr(7, 3, 0));
    auto_lock_i = 1'b0;
    w0 = n_wr;
    st(adr(7, 3, 0), 32'h3333_4444);
    settle();
    chk("R8 auto-locked line keeps store", n_wr - w0, 0);
    ld(adr(7, 3, 0));
    chk("R8 auto-locked data", res, 32'h3333_4444);
    global_lock_i = 1'b1;
    r0 = n_rd;
    ld(adr(8, 2, 0));
    chk("R9 glock fills invalid way", n_rd - r0, 4);
    r0 = n_rd;
    ld(adr(9, 2, 0));
    chk("R9 glock no replace single read", n_rd - r0, 1);
    chk("R9 glock bypass data", res, base(adr(9, 2, 0)));
    ld(adr(9, 2, 0));
    chk("R9 glock still not allocated", n_rd - r0, 2);
    r0 = n_rd;
    ld(adr(8, 2, 3));
    ld(adr(6, 2, 1));
    chk("R9 both lines kept", n_rd - r0, 0);
    global_lock_i = 1'b0;
    r0 = n_rd;
    ld(adr(9, 2, 0));
    chk("R9 victim is unlocked way", n_rd - r0, 4);
    r0 = n_rd;
    ld(adr(6, 2, 1));
    chk("R9 locked line survives", n_rd - r0, 0);
    chk("R9 locked data kept", res, 32'h1111_2222);
    @(negedge clk_i); unlock_all_i = 1'b1;
    @(negedge clk_i); unlock_all_i = 1'b0;
    w0 = n_wr;
    st(adr(6, 2, 1), 32'h5555_6666);
    settle();
    chk("R10 unlocked line writes through", n_wr - w0, 1);
    chk("R10 memory value", mval(adr(6, 2, 1)), 32'h5555_6666);

    // Write buffer depth: R11
    do_reset();
    hold = 1'b1;
    w0 = n_wr;
    for (int i = 0; i < 4; i++) begin
      st(adr(10, i, 0), 32'hA000_0000 + 32'(i), 1'b1);
      chk("R11 store accepted while not full", acc_cyc, 0);
    end
    fork st(adr(10, 0, 1), 32'hA000_0009, 1'b1); join_none
    repeat (10) @(negedge clk_i);
    #2;
    chk("R11 fifth store stalls", {31'b0, acc_done}, 32'd0);
    chk("R11 nothing written while held", n_wr - w0, 0);
    hold = 1'b0;
    wait (acc_done);
    settle();
    chk("R11 all stores drained", n_wr - w0, 5);
    chk("R11 fifth store value", mval(adr(10, 0, 1)), 32'hA000_0009);

    // Load miss behind queued writes: R12
    hold = 1'b1;
    w0 = n_wr; r0 = n_rd;
    for (int i = 0; i < 3; i++) st(adr(11, i, 2), 32'hB000_0000 + 32'(i), 1'b1);
    fork ld(adr(12, 3, 1)); join_none
    repeat (10) @(negedge clk_i);
    #2;
    chk("R12 load waits", {31'b0, acc_done}, 32'd0);
    chk("R12 no read yet", n_rd - r0, 0);
    hold = 1'b0;
    wait (acc_done);
    chk("R12 writes done before read", last_rd_wr - w0, 3);
    chk("R12 load data", res, base(adr(12, 3, 1)));

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule